// File: doc/BRIEF.md
# MESI Snooping Coherence Line Controller

This block holds the coherence state of a write-back private cache that shares a snooping bus with its peers. It keeps a small direct-indexed array of tags and two-bit line states. The array is eight entries by default. Commands come from two sides. The core side issues reads and writes. The bus side delivers snooped get requests and get-with-invalidate requests. For every command the block updates the addressed entry and presents exactly one bus action in the same cycle: nothing, a write-back of the line, a get, or a get-with-invalidate.

On a snooped get that hits a valid line, the block raises its contribution to the bus shared signal. The bus combines those contributions as a wired-OR. On a core read miss the block samples the combined shared input to choose between Shared and Exclusive. The lower level always supplies the data, so no data moves between private caches. Data storage, the lower level and bus arbitration are not part of this block.

Top module: `mesi_ctrl`

## Requirements
- R1: After reset every entry is Invalid. A snoop to any address then gives no action and no shared contribution, and a core read gives a get.
- R2: `act_o` encodes the action as 0 none, 1 write-back, 2 get, 3 get-with-invalidate. It is valid in the same cycle as the command, with `act_addr_o` giving the line address. A cycle with no command gives none. `core_vld` and `snp_vld` are never high in the same cycle.
- R3: A core read that misses issues a get. The entry installs the new tag in Exclusive when `bus_shared_i` is low and in Shared when it is high. The index is address bits [2:0] and the tag is the remaining upper bits.
- R4: A core read that hits a line in Shared, Exclusive or Modified gives no action and leaves the state unchanged.
- R5: A core write to an Invalid or Shared line issues a get-with-invalidate, and a core write to an Exclusive or Modified line gives no action. In all four cases the line ends Modified.
- R6: A snooped get that hits raises `shared_o`. From Modified it writes the line back, and from Exclusive or Shared it gives no action. The line ends Shared.
- R7: A snooped get-with-invalidate that hits ends the line Invalid. It writes the line back only from Modified and never raises `shared_o`.
- R8: A snoop whose tag differs from the stored tag, or that finds the entry Invalid, gives no action, keeps `shared_o` low and leaves the entry unchanged.
- R9: A core command that maps to an entry holding another tag is handled by the victim's state. A Modified victim is written back with the victim's address, the entry becomes Invalid and the command is not performed. A clean victim is dropped and the command proceeds as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| core_vld | input | 1 | Core command present |
| core_wr | input | 1 | 1 write, 0 read |
| core_addr | input | ADDR_W | Core line address |
| snp_vld | input | 1 | Snooped bus command present |
| snp_inv | input | 1 | 1 get-with-invalidate, 0 get |
| snp_addr | input | ADDR_W | Snooped line address |
| bus_shared_i | input | 1 | Combined shared signal from the other caches |
| shared_o | output | 1 | This cache's shared contribution |
| act_o | output | 2 | Bus action for the current command |
| act_addr_o | output | ADDR_W | Line address the action refers to |

## Verification
The bench builds the block with its defaults: an 8-bit line address and eight entries. This gives a 3-bit index and a 5-bit tag, so two addresses that share index 1 but differ in tag are easy to write. Every state can be reached and left through each of the four commands. Victim write-back, clean victim replacement and snoops that miss on the tag all fall on a few hand-picked addresses. A reset applied while an entry is Modified shows that the array returns to Invalid.

// File: rtl/mesi_ctrl_pkg.sv
package mesi_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_FLUSH = 2'd1,
    ACT_GET   = 2'd2,
    ACT_GETI  = 2'd3
  } bus_act_t;

  typedef enum logic [1:0] {
    CMD_CORE_RD  = 2'd0,
    CMD_CORE_WR  = 2'd1,
    CMD_SNP_GET  = 2'd2,
    CMD_SNP_GETI = 2'd3
  } cmd_t;

  typedef struct packed {
    line_st_t nxt;
    bus_act_t act;
    logic     shared;
    logic     tag_wr;
    logic     victim;
  } xfer_t;
endpackage

// File: rtl/mesi_rst_sync.sv
module mesi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mesi_cmd_sel.sv
module mesi_cmd_sel import mesi_ctrl_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              core_vld,
  input  logic              core_wr,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              snp_vld,
  input  logic              snp_inv,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              cmd_vld,
  output cmd_t              cmd,
  output logic [ADDR_W-1:0] cmd_addr
);
  always_comb begin
    cmd_vld = core_vld | snp_vld;
    if (snp_vld) begin
      cmd      = snp_inv ? CMD_SNP_GETI : CMD_SNP_GET;
      cmd_addr = snp_addr;
    end else begin
      cmd      = core_wr ? CMD_CORE_WR : CMD_CORE_RD;
      cmd_addr = core_addr;
    end
  end
endmodule

// File: rtl/mesi_tag_store.sv
module mesi_tag_store import mesi_ctrl_pkg::*; #(
  parameter int LINES = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output line_st_t         rd_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_tag_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_t         wr_st
);
  line_st_t         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t st_d;
    logic     sel;

    always_comb begin
      sel  = wr_en && (wr_idx == IDX_W'(g));
      st_d = st_q[g];
      if (sel) st_d = wr_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= ST_I;
      else        st_q[g] <= st_d;
    end

    always_ff @(posedge clk) begin
      if (sel && wr_tag_en) tag_q[g] <= wr_tag;
    end
  end

  assign rd_st  = st_q[rd_idx];
  assign rd_tag = tag_q[rd_idx];
endmodule

// File: rtl/mesi_xfer.sv
module mesi_xfer import mesi_ctrl_pkg::*; (
  input  cmd_t     cmd,
  input  logic     tag_hit,
  input  line_st_t cur_st,
  input  logic     shared_in,
  output xfer_t    xf
);
  line_st_t eff;
  logic     dirty_victim;

  always_comb begin
    eff          = tag_hit ? cur_st : ST_I;
    dirty_victim = !tag_hit && (cur_st == ST_M);

    xf        = '0;
    xf.nxt    = cur_st;
    xf.act    = ACT_NONE;

    unique case (cmd)
      CMD_CORE_RD: begin
        if (dirty_victim) begin
          xf.act = ACT_FLUSH; xf.nxt = ST_I; xf.victim = 1'b1;
        end else if (eff == ST_I) begin
          xf.act    = ACT_GET;
          xf.nxt    = shared_in ? ST_S : ST_E;
          xf.tag_wr = 1'b1;
        end
      end
      CMD_CORE_WR: begin
        if (dirty_victim) begin
          xf.act = ACT_FLUSH; xf.nxt = ST_I; xf.victim = 1'b1;
        end else begin
          xf.nxt = ST_M;
          if (eff == ST_I) begin
            xf.act = ACT_GETI; xf.tag_wr = 1'b1;
          end else if (eff == ST_S) begin
            xf.act = ACT_GETI;
          end
        end
      end
      CMD_SNP_GET: begin
        if (eff != ST_I) begin
          xf.shared = 1'b1;
          xf.nxt    = ST_S;
          if (eff == ST_M) xf.act = ACT_FLUSH;
        end
      end
      CMD_SNP_GETI: begin
        if (eff != ST_I) begin
          xf.nxt = ST_I;
          if (eff == ST_M) xf.act = ACT_FLUSH;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl import mesi_ctrl_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_vld,
  input  logic              core_wr,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              snp_vld,
  input  logic              snp_inv,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              bus_shared_i,
  output logic              shared_o,
  output logic [1:0]        act_o,
  output logic [ADDR_W-1:0] act_addr_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              rst_sync_n;
  logic              cmd_vld;
  cmd_t              cmd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [TAG_W-1:0]  stored_tag;
  line_st_t          stored_st;
  logic              tag_hit;
  xfer_t             xf;

  mesi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mesi_cmd_sel #(.ADDR_W(ADDR_W)) u_sel (
    .core_vld(core_vld), .core_wr(core_wr), .core_addr(core_addr),
    .snp_vld(snp_vld), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .cmd_vld(cmd_vld), .cmd(cmd), .cmd_addr(cmd_addr)
  );

  assign idx     = cmd_addr[IDX_W-1:0];
  assign tag     = cmd_addr[ADDR_W-1:IDX_W];
  assign tag_hit = (stored_tag == tag);

  mesi_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_idx(idx), .rd_tag(stored_tag), .rd_st(stored_st),
    .wr_en(cmd_vld), .wr_idx(idx), .wr_tag_en(xf.tag_wr),
    .wr_tag(tag), .wr_st(xf.nxt)
  );

  mesi_xfer u_xfer (
    .cmd(cmd), .tag_hit(tag_hit), .cur_st(stored_st),
    .shared_in(bus_shared_i), .xf(xf)
  );

  assign act_o      = cmd_vld ? xf.act : ACT_NONE;
  assign shared_o   = cmd_vld & xf.shared;
  assign act_addr_o = xf.victim ? {stored_tag, idx} : cmd_addr;
endmodule

// File: rtl/mesi_ctrl_chk.sv
module mesi_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_vld,
  input logic              core_wr,
  input logic [ADDR_W-1:0] core_addr,
  input logic              snp_vld,
  input logic              snp_inv,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              shared_o,
  input logic [1:0]        act_o
);
  // R2: input contract, one command source per cycle
  p_one_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_vld && snp_vld));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_vld && !snp_vld) |-> (act_o == 2'd0 && !shared_o));

  p_read_no_geti_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_vld && !core_wr) |-> (act_o != 2'd3));

  p_read_after_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_vld && !core_wr && act_o == 2'd2) |=>
    ((core_vld && !core_wr && core_addr == $past(core_addr)) -> act_o == 2'd0));

  p_write_no_get_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_vld && core_wr) |-> (act_o != 2'd2));

  p_write_twice_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_vld && core_wr && act_o == 2'd3) |=>
    ((core_vld && core_wr && core_addr == $past(core_addr)) -> act_o == 2'd0));

  p_shared_only_get_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shared_o |-> (snp_vld && !snp_inv));

  p_inv_then_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_vld && snp_inv) |=>
    ((snp_vld && snp_addr == $past(snp_addr)) -> (act_o == 2'd0 && !shared_o)));

  p_snoop_no_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_vld |-> (act_o == 2'd0 || act_o == 2'd1));
endmodule

bind mesi_ctrl mesi_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_vld(core_vld), .core_wr(core_wr),
  .core_addr(core_addr), .snp_vld(snp_vld), .snp_inv(snp_inv),
  .snp_addr(snp_addr), .shared_o(shared_o), .act_o(act_o)
);

// File: tb/mesi_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_ctrl_bench;
  localparam int ADDR_W = 8;
  localparam int LINES  = 8;

  localparam logic [1:0] KC = 2'd1;  // core command
  localparam logic [1:0] KS = 2'd2;  // snoop command
  localparam logic [1:0] N = 2'd0, F = 2'd1, G = 2'd2, X = 2'd3;
  localparam int NV = 23;

  // {req[3:0], kind[1:0], op, addr[7:0], shared_in, exp_act[1:0], exp_shared, exp_addr[7:0]}
  localparam logic [26:0] VEC [NV] = '{
    {4'd3, KC, 1'b0, 8'h09, 1'b0, G, 1'b0, 8'h09},  // R3 read miss -> E
    {4'd8, KS, 1'b0, 8'h02, 1'b0, N, 1'b0, 8'h02},  // R8 snoop on invalid
    {4'd6, KS, 1'b0, 8'h09, 1'b0, N, 1'b1, 8'h09},  // R6 E -> S
    {4'd5, KC, 1'b1, 8'h09, 1'b0, X, 1'b0, 8'h09},  // R5 S write
    {4'd4, KC, 1'b0, 8'h09, 1'b0, N, 1'b0, 8'h09},  // R4 M read
    {4'd6, KS, 1'b0, 8'h09, 1'b0, F, 1'b1, 8'h09},  // R6 M -> S flush
    {4'd7, KS, 1'b1, 8'h09, 1'b0, N, 1'b0, 8'h09},  // R7 S -> I
    {4'd3, KC, 1'b0, 8'h09, 1'b1, G, 1'b0, 8'h09},  // R3 read miss shared -> S
    {4'd4, KC, 1'b0, 8'h09, 1'b0, N, 1'b0, 8'h09},  // R4 S read
    {4'd5, KC, 1'b1, 8'h09, 1'b0, X, 1'b0, 8'h09},  // R5 S write -> M
    {4'd7, KS, 1'b1, 8'h09, 1'b0, F, 1'b0, 8'h09},  // R7 M -> I flush
    {4'd5, KC, 1'b1, 8'h09, 1'b0, X, 1'b0, 8'h09},  // R5 I write -> M
    {4'd9, KC, 1'b0, 8'h11, 1'b0, F, 1'b0, 8'h09},  // R9 dirty victim
    {4'd9, KC, 1'b0, 8'h11, 1'b0, G, 1'b0, 8'h11},  // R9 retry -> E
    {4'd8, KS, 1'b0, 8'h09, 1'b0, N, 1'b0, 8'h09},  // R8 tag mismatch
    {4'd5, KC, 1'b1, 8'h11, 1'b0, N, 1'b0, 8'h11},  // R5 E write -> M
    {4'd6, KS, 1'b0, 8'h11, 1'b0, F, 1'b1, 8'h11},  // R6 M -> S
    {4'd3, KC, 1'b0, 8'h02, 1'b1, G, 1'b0, 8'h02},  // R3 -> S
    {4'd9, KC, 1'b1, 8'h1A, 1'b0, X, 1'b0, 8'h1A},  // R9 clean victim
    {4'd8, KS, 1'b1, 8'h02, 1'b0, N, 1'b0, 8'h02},  // R8 mismatch after replace
    {4'd4, KC, 1'b0, 8'h1A, 1'b0, N, 1'b0, 8'h1A},  // R4 M read
    {4'd7, KS, 1'b1, 8'h11, 1'b0, N, 1'b0, 8'h11},  // R7 S -> I no flush
    {4'd8, KS, 1'b0, 8'h11, 1'b0, N, 1'b0, 8'h11}   // R8 now invalid
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              core_vld, core_wr, snp_vld, snp_inv, bus_shared_i;
  logic [ADDR_W-1:0] core_addr, snp_addr;
  logic              shared_o;
  logic [1:0]        act_o;
  logic [ADDR_W-1:0] act_addr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  mesi_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES)) u_mesi_ctrl (
    .clk(clk), .rst_n(rst_n), .core_vld(core_vld), .core_wr(core_wr),
    .core_addr(core_addr), .snp_vld(snp_vld), .snp_inv(snp_inv),
    .snp_addr(snp_addr), .bus_shared_i(bus_shared_i), .shared_o(shared_o),
    .act_o(act_o), .act_addr_o(act_addr_o)
  );

  task automatic check(input int req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    core_vld = 1'b0; snp_vld = 1'b0; core_wr = 1'b0; snp_inv = 1'b0;
    bus_shared_i = 1'b0; core_addr = '0; snp_addr = '0;
  endtask

  // drive one command at the falling edge, sample its outputs before the next rise
  task automatic issue(input logic [1:0] kind, input logic op, input logic [7:0] addr,
                       input logic shin);
    @(negedge clk);
    core_vld = (kind == KC); core_wr = op; core_addr = addr;
    snp_vld  = (kind == KS); snp_inv = op; snp_addr  = addr;
    bus_shared_i = shin;
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(); idle();
    rst_n = 1'b1;
    repeat (4) idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    core_vld = 0; core_wr = 0; snp_vld = 0; snp_inv = 0; bus_shared_i = 0;
    core_addr = '0; snp_addr = '0;
    do_reset();

    // R1: every entry starts Invalid
    for (int i = 0; i < LINES; i++) begin
      issue(KS, 1'b0, 8'(i), 1'b0);
      check(1, "reset snoop act", int'(act_o), 0);
      check(1, "reset snoop shared", int'(shared_o), 0);
    end

    // R2: idle cycle gives no action
    idle(); #2;
    check(2, "idle act", int'(act_o), 0);
    check(2, "idle shared", int'(shared_o), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [26:0] e;
      e = VEC[v];
      issue(e[22:21], e[20], e[19:12], e[11]);
      check(int'(e[26:23]), $sformatf("vec %0d act", v), int'(act_o), int'(e[10:9]));
      check(int'(e[26:23]), $sformatf("vec %0d shared", v), int'(shared_o), int'(e[8]));
      if (e[10:9] != N)
        check(2, $sformatf("vec %0d act addr", v), int'(act_addr_o), int'(e[7:0]));
    end

    // R1: reset while an entry is Modified returns it to Invalid
    issue(KC, 1'b1, 8'h03, 1'b0);
    check(5, "write before reset", int'(act_o), int'(X));
    do_reset();
    issue(KS, 1'b0, 8'h03, 1'b0);
    check(1, "post reset snoop act", int'(act_o), 0);
    check(1, "post reset snoop shared", int'(shared_o), 0);
    issue(KC, 1'b0, 8'h03, 1'b0);
    check(1, "post reset read act", int'(act_o), int'(G));
    // R3: the fill above left Exclusive, so a write is silent
    issue(KC, 1'b1, 8'h03, 1'b0);
    check(3, "exclusive after unshared fill", int'(act_o), 0);
    idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule